// File: doc/BRIEF.md
# Canonical Huffman Symbol Decoder

This block turns a serial stream of code bits into one symbol per decode, using canonical Huffman tables held in local storage. After a start pulse it asks for bits one at a time, grows the code by one bit per accepted bit, and checks it against the largest legal code of the current length. When the code fits, it adds a per-length offset to form an index into the symbol list, and emits that symbol together with its code length as a one-cycle pulse. If sixteen bits pass with no match, it raises a one-cycle error and goes back to idle.

The tables are loaded through a plain write port while the decoder is idle. There are three tables: the largest code per length, the offset per length, and the list of symbol values. The bit input is a valid/ready stream. `bit_ready` is high for as long as a decode is running. A bit is consumed only on a clock edge where both `bit_valid` and `bit_ready` are high. A low `bit_valid` stalls the search for as many cycles as it stays low, and no state changes during the stall.

Top module: `huff_decoder`

## Requirements
- R1: After reset, `busy`, `bit_ready`, `sym_valid` and `err` are all low. Every largest-code entry is all ones and every offset and symbol entry is zero.
- R2: A `start` pulse while idle makes `busy` and `bit_ready` high from the next cycle until the decode ends.
- R3: While busy, a cycle with `bit_valid` low consumes no bit. The decode keeps its length and code, and produces no output.
- R4: The first accepted bit is the whole code at length 1. Each further accepted bit shifts the code left by one and enters at the LSB. Each accepted bit causes exactly one comparison, at a length equal to the number of bits accepted so far.
- R5: A code matches at length L when, as a 17-bit signed value, it is not greater than the largest-code entry for L. An entry of all ones (-1) means length L has no codes.
- R6: On a match, the symbol entry at index (code + offset[L]) mod 256 is put on `sym_data`, and L is put on `sym_len`. `sym_valid` pulses for one cycle, in the cycle after the last bit is accepted, and `busy` is low in that same cycle.
- R7: If there is no match at length 16, `err` pulses for one cycle in the cycle after the 16th bit is accepted. The decoder returns to idle, and `sym_valid` stays low.
- R8: Table writes presented while `busy` is high are discarded.
- R9: A `start` pulse while busy has no effect. The running decode finishes normally and does not restart.
- R10: The write port encoding is `tbl_sel` 0 = largest code, at `tbl_addr[3:0]` = L-1, taking 17 bits of `tbl_wdata`. `tbl_sel` 1 = offset, at L-1, taking the low 8 bits. `tbl_sel` 2 = symbol, at `tbl_addr`, taking the low 8 bits. A write happens on a rising edge where `tbl_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one symbol decode (used only when idle) |
| busy | output | 1 | A decode is running |
| bit_valid | input | 1 | `bit_data` holds a code bit |
| bit_ready | output | 1 | The decoder accepts a bit this cycle |
| bit_data | input | 1 | Next code bit, most significant bit of the code first |
| sym_valid | output | 1 | One-cycle pulse: the symbol has been decoded |
| sym_data | output | 8 | Decoded symbol value |
| sym_len | output | 5 | Code length of the decoded symbol |
| err | output | 1 | One-cycle pulse: no code matched within 16 bits |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 largest code, 1 offset, 2 symbol |
| tbl_addr | input | 8 | Length index minus one, or symbol index |
| tbl_wdata | input | 17 | Write data |

## Verification
The assertions assume that `start` and table writes come from a controller that respects `busy`, and that the loaded tables form a valid canonical set, so that a resolved index lands on a loaded symbol entry. The bench builds each table set arithmetically from a list of counts per length, loads it only while idle, and then feeds each symbol's own code bit by bit. A mid-decode write and a repeated start are driven on purpose, and both are checked only at the ports. The bench also uses one all-ones stream; because each code space is incomplete, that stream can only end in the length-overflow error.

// File: rtl/huff_pkg.sv
package huff_pkg;
  typedef enum logic [1:0] {
    TSEL_MAXC  = 2'd0,
    TSEL_DELTA = 2'd1,
    TSEL_SYM   = 2'd2,
    TSEL_NONE  = 2'd3
  } tsel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dec_state_e;
endpackage

// File: rtl/huff_tbl_store.sv
module huff_tbl_store
  import huff_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int SYM_W   = 8,
  parameter int NSYM    = 256,
  localparam int LSEL_W = $clog2(MAX_LEN),
  localparam int IDX_W  = $clog2(NSYM),
  localparam int MC_W   = MAX_LEN + 1,
  localparam int AW     = (IDX_W > LSEL_W) ? IDX_W : LSEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [MC_W-1:0]          wr_data_i,
  input  logic [LSEL_W-1:0]        rd_lsel_i,
  output logic signed [MC_W-1:0]   rd_maxc_o,
  output logic [IDX_W-1:0]         rd_delta_o,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [SYM_W-1:0]         rd_sym_o
);
  logic                    wr_ok;
  logic [MC_W-1:0]         maxc_q  [MAX_LEN];
  logic [IDX_W-1:0]        delta_q [MAX_LEN];
  logic [SYM_W-1:0]        sym_q   [NSYM];
  logic [MAX_LEN*MC_W-1:0] maxc_flat;
  logic [MAX_LEN*IDX_W-1:0] delta_flat;

  assign wr_ok = wr_en_i && !busy_i;

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        maxc_q[g]  <= '1;
        delta_q[g] <= '0;
      end else if (wr_ok && wr_addr_i[LSEL_W-1:0] == LSEL_W'(g)) begin
        if (tsel_e'(wr_sel_i) == TSEL_MAXC)  maxc_q[g]  <= wr_data_i;
        if (tsel_e'(wr_sel_i) == TSEL_DELTA) delta_q[g] <= wr_data_i[IDX_W-1:0];
      end
    end
    assign maxc_flat[g*MC_W +: MC_W]    = maxc_q[g];
    assign delta_flat[g*IDX_W +: IDX_W] = delta_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSYM; i++) sym_q[i] <= '0;
    end else if (wr_ok && tsel_e'(wr_sel_i) == TSEL_SYM) begin
      sym_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i[SYM_W-1:0];
    end
  end

  assign rd_maxc_o  = signed'(maxc_q[rd_lsel_i]);
  assign rd_delta_o = delta_q[rd_lsel_i];
  assign rd_sym_o   = sym_q[rd_idx_i];

  // R8
  tbl_len_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(maxc_flat) && $stable(delta_flat));

  // R8
  tbl_sym_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wr_en_i) |=>
      sym_q[$past(wr_addr_i[IDX_W-1:0])] == $past(sym_q[wr_addr_i[IDX_W-1:0]]));
endmodule

// File: rtl/huff_code_cmp.sv
module huff_code_cmp #(
  parameter int MAX_LEN = 16,
  parameter int NSYM    = 256,
  localparam int IDX_W  = $clog2(NSYM),
  localparam int MC_W   = MAX_LEN + 1
) (
  input  logic [MAX_LEN-1:0]       code_i,
  input  logic signed [MC_W-1:0]   maxc_i,
  input  logic [IDX_W-1:0]         delta_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic signed [MC_W-1:0] code_s;

  always_comb begin
    code_s = signed'({1'b0, code_i});
    hit_o  = (code_s <= maxc_i);
    idx_o  = code_i[IDX_W-1:0] + delta_i;
  end
endmodule

// File: rtl/huff_len_search.sv
module huff_len_search
  import huff_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int SYM_W   = 8,
  localparam int LSEL_W = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               bit_valid_i,
  input  logic               bit_data_i,
  output logic               bit_ready_o,
  output logic               busy_o,
  output logic [MAX_LEN-1:0] code_nx_o,
  output logic [LSEL_W-1:0]  lsel_o,
  input  logic               hit_i,
  input  logic [SYM_W-1:0]   sym_i,
  output logic               sym_valid_o,
  output logic [SYM_W-1:0]   sym_data_o,
  output logic [LEN_W-1:0]   sym_len_o,
  output logic               err_o
);
  dec_state_e               st_q;
  logic [LSEL_W-1:0]        lsel_q;
  logic [MAX_LEN-2:0]       code_q;
  logic                     take;

  assign busy_o      = (st_q == ST_RUN);
  assign bit_ready_o = busy_o;
  assign take        = busy_o && bit_valid_i;
  assign code_nx_o   = {code_q, bit_data_i};
  assign lsel_o      = lsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      lsel_q      <= '0;
      code_q      <= '0;
      sym_valid_o <= 1'b0;
      sym_data_o  <= '0;
      sym_len_o   <= '0;
      err_o       <= 1'b0;
    end else begin
      sym_valid_o <= 1'b0;
      err_o       <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            lsel_q <= '0;
            code_q <= '0;
          end
        end
        ST_RUN: begin
          if (take) begin
            if (hit_i) begin
              sym_valid_o <= 1'b1;
              sym_data_o  <= sym_i;
              sym_len_o   <= LEN_W'(lsel_q) + LEN_W'(1);
              st_q        <= ST_IDLE;
            end else if (lsel_q == LSEL_W'(MAX_LEN - 1)) begin
              err_o <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              lsel_q <= lsel_q + LSEL_W'(1);
              code_q <= code_nx_o[MAX_LEN-2:0];
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o && bit_ready_o);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bit_valid_i) |=> busy_o && $stable(lsel_q) && $stable(code_q) && !sym_valid_o && !err_o);

  // R4
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit_i && lsel_q != LSEL_W'(MAX_LEN - 1)) |=> busy_o && lsel_q == $past(lsel_q) + LSEL_W'(1));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |=> !sym_valid_o);

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !sym_valid_o);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !bit_valid_i) |=> busy_o && $stable(lsel_q));
endmodule

// File: rtl/huff_decoder.sv
module huff_decoder #(
  parameter int MAX_LEN = 16,
  parameter int SYM_W   = 8,
  parameter int NSYM    = 256,
  localparam int LSEL_W = $clog2(MAX_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(NSYM),
  localparam int MC_W   = MAX_LEN + 1,
  localparam int AW     = (IDX_W > LSEL_W) ? IDX_W : LSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_data,
  output logic              sym_valid,
  output logic [SYM_W-1:0]  sym_data,
  output logic [LEN_W-1:0]  sym_len,
  output logic              err,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [MC_W-1:0]   tbl_wdata
);
  logic [MAX_LEN-1:0]      code_nx;
  logic [LSEL_W-1:0]       lsel;
  logic signed [MC_W-1:0]  maxc;
  logic [IDX_W-1:0]        delta;
  logic [IDX_W-1:0]        idx;
  logic [SYM_W-1:0]        sym_rd;
  logic                    hit;

  huff_tbl_store #(.MAX_LEN(MAX_LEN), .SYM_W(SYM_W), .NSYM(NSYM)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy),
    .wr_en_i    (tbl_we),
    .wr_sel_i   (tbl_sel),
    .wr_addr_i  (tbl_addr),
    .wr_data_i  (tbl_wdata),
    .rd_lsel_i  (lsel),
    .rd_maxc_o  (maxc),
    .rd_delta_o (delta),
    .rd_idx_i   (idx),
    .rd_sym_o   (sym_rd)
  );

  huff_code_cmp #(.MAX_LEN(MAX_LEN), .NSYM(NSYM)) u_cmp (
    .code_i  (code_nx),
    .maxc_i  (maxc),
    .delta_i (delta),
    .hit_o   (hit),
    .idx_o   (idx)
  );

  huff_len_search #(.MAX_LEN(MAX_LEN), .SYM_W(SYM_W)) u_search (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .bit_valid_i (bit_valid),
    .bit_data_i  (bit_data),
    .bit_ready_o (bit_ready),
    .busy_o      (busy),
    .code_nx_o   (code_nx),
    .lsel_o      (lsel),
    .hit_i       (hit),
    .sym_i       (sym_rd),
    .sym_valid_o (sym_valid),
    .sym_data_o  (sym_data),
    .sym_len_o   (sym_len),
    .err_o       (err)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bit_ready);

  // R6
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !err && !busy);
endmodule

// File: tb/huff_decoder_test.sv
module huff_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy;
  logic        bit_valid = 1'b0;
  logic        bit_ready;
  logic        bit_data = 1'b0;
  logic        sym_valid;
  logic [7:0]  sym_data;
  logic [4:0]  sym_len;
  logic        err;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = 2'd3;
  logic [7:0]  tbl_addr = '0;
  logic [16:0] tbl_wdata = '0;

  int errors = 0;
  int checks = 0;

  int cnt   [1:16];
  int mcv   [1:16];
  int dlv   [1:16];
  int scode [0:255];
  int slen  [0:255];
  int sval  [0:255];
  int nsym;

  always #4 clk = ~clk;

  huff_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .sym_valid(sym_valid), .sym_data(sym_data), .sym_len(sym_len), .err(err),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic wr(input int sel, input int addr, input int data);
    tbl_we    = 1'b1;
    tbl_sel   = 2'(sel);
    tbl_addr  = 8'(addr);
    tbl_wdata = 17'(data);
    @(negedge clk);
    tbl_we  = 1'b0;
    tbl_sel = 2'd3;
  endtask

  // canonical table built from the per-length counts (R10 write encoding)
  task automatic build(input int cfg);
    int code;
    int k;
    for (int l = 1; l <= 16; l++) cnt[l] = 0;
    if (cfg == 0) begin
      cnt[2] = 1; cnt[3] = 5; cnt[4] = 1; cnt[5] = 1; cnt[6] = 1;
      cnt[7] = 1; cnt[8] = 1; cnt[9] = 1;
    end else begin
      cnt[1] = 1; cnt[2] = 1; cnt[4] = 2; cnt[8] = 3; cnt[16] = 4;
    end
    code = 0;
    k = 0;
    for (int l = 1; l <= 16; l++) begin
      if (cnt[l] == 0) begin
        mcv[l] = -1;
        dlv[l] = 0;
      end else begin
        mcv[l] = code + cnt[l] - 1;
        dlv[l] = k - code;
        for (int i = 0; i < cnt[l]; i++) begin
          scode[k + i] = code + i;
          slen[k + i]  = l;
        end
        k    += cnt[l];
        code += cnt[l];
      end
      code = code << 1;
    end
    nsym = k;
    for (int s = 0; s < nsym; s++) sval[s] = (s * 73 + 5 + cfg * 17) & 255;
    for (int l = 1; l <= 16; l++) begin
      wr(0, l - 1, mcv[l] & 17'h1FFFF);
      wr(1, l - 1, dlv[l] & 255);
    end
    for (int s = 0; s < nsym; s++) wr(2, s, sval[s]);
  endtask

  // gap: stall before each odd bit; poke: write + start during the decode
  task automatic decode(input int k, input bit gap, input bit poke);
    int len;
    len = slen[k];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && bit_ready, "R2", "busy/ready after start", int'(busy), 1);
    for (int i = 0; i < len; i++) begin
      if (gap && (i % 2 == 1)) begin
        bit_valid = 1'b0;
        @(negedge clk);
        chk(busy && !sym_valid && !err, "R3", "stall holds", int'(sym_valid), 0);
      end
      bit_valid = 1'b1;
      bit_data  = 1'((scode[k] >> (len - 1 - i)) & 1);
      if (poke && i == 0) begin
        start     = 1'b1;
        tbl_we    = 1'b1;
        tbl_sel   = 2'd2;
        tbl_addr  = 8'(k);
        tbl_wdata = 17'((~sval[k]) & 255);
      end
      @(negedge clk);
      start  = 1'b0;
      tbl_we = 1'b0;
      if (i < len - 1)
        chk(busy && !sym_valid && !err, "R4", "no early result", int'(sym_valid), 0);
    end
    bit_valid = 1'b0;
    chk(sym_valid === 1'b1, "R6", "sym_valid pulse", int'(sym_valid), 1);
    chk(sym_data === 8'(sval[k]), poke ? "R8" : "R6", "symbol value", int'(sym_data), sval[k]);
    chk(sym_len === 5'(len), "R4", "code length", int'(sym_len), len);
    chk(!busy && !err, "R5", "idle after match", int'(busy), 0);
    @(negedge clk);
    chk(!sym_valid, "R6", "pulse is one cycle", int'(sym_valid), 0);
    if (poke) chk(!busy && !bit_ready, "R9", "no restart", int'(busy), 0);
  endtask

  task automatic all_ones();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      bit_valid = 1'b1;
      bit_data  = 1'b1;
      @(negedge clk);
      if (i < 15) chk(busy && !err, "R7", "no early error", int'(err), 0);
    end
    bit_valid = 1'b0;
    chk(err === 1'b1, "R7", "error pulse", int'(err), 1);
    chk(!sym_valid && !busy, "R7", "no symbol, idle", int'(sym_valid), 0);
    @(negedge clk);
    chk(!err, "R7", "error one cycle", int'(err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bit_ready && !sym_valid && !err, "R1", "reset outputs", int'(busy), 0);
    // R1/R5: unloaded table (all max entries -1) must end in error
    all_ones();
    for (int cfg = 0; cfg < 2; cfg++) begin
      build(cfg);
      for (int s = 0; s < nsym; s++) decode(s, 1'b0, 1'b0);
      for (int s = 0; s < nsym; s++) decode(s, 1'b1, 1'b0);
      decode(nsym - 1, 1'b0, 1'b1);
      decode(0, 1'b1, 1'b1);
      all_ones();
    end
    summary();
    $finish;
  end
endmodule